// File: doc/BRIEF.md
# SDRAM Single-Word Access Controller

This block sits between a simple request port and an already initialized single-data-rate SDRAM. Each accepted request carries a flat word address, a write flag, write data and a byte mask. The block runs one complete access per request. It opens the addressed row, waits the row-to-column delay, and then issues a READ or WRITE with automatic precharge. After that it holds off until the bank has recovered. For a read, the returned word is captured after the CAS latency and handed back with a one-cycle valid strobe.

Between accesses, a free-running interval counter raises a refresh demand. A pending demand waits for any running access to finish. It then blocks new requests and issues an auto-refresh, so refresh always takes precedence over waiting user traffic.

All memory-side outputs come straight from registers. The data bus is split into an output word, an output enable and an input word, and the tri-state buffer sits outside the block.

Top module: `sdram_word_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, the command is NOP, `sd_dq_oe` is 0 and `rd_valid` is 0.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100 and AUTO-REFRESH=0001. No other code ever appears.
- R3: The flat address splits as bank=addr[21:20], row=addr[19:8], column=addr[7:0]. ACTIVE carries the bank on `sd_ba` and the row on `sd_a`. The READ or WRITE that follows names the same bank, with the column on `sd_a[7:0]`.
- R4: During READ and WRITE, `sd_a[10]` is 1 to request automatic precharge, and `sd_a` bits 8, 9 and 11 are 0.
- R5: READ or WRITE follows its ACTIVE exactly T_RCD cycles later (2 by default), with NOPs in between.
- R6: `sd_dq_oe` is 1 only in the cycle that carries WRITE. In that cycle `sd_dq_out` is the request's write data and `sd_dqm` is the request's mask, where bit 0 guards DQ[7:0], bit 1 guards DQ[15:8], and a 1 blocks that byte from being written.
- R7: During READ, `sd_dqm` is 00. `rd_valid` pulses for exactly one cycle, CAS_LAT+1 cycles after the READ cycle, with `rd_data` equal to the word on `sd_dq_in` CAS_LAT cycles after READ.
- R8: An ACTIVE or AUTO-REFRESH comes more than T_WR+T_RP cycles after a WRITE, more than CAS_LAT+T_RP cycles after a READ, and more than T_RFC cycles after an AUTO-REFRESH.
- R9: A request is taken on a rising edge with `req_valid` and `req_ready` both 1. `req_ready` is 0 in every cycle that carries a non-NOP command.
- R10: With no user traffic, consecutive AUTO-REFRESH commands are exactly REFI_CYC cycles apart.
- R11: Under continuous user traffic, a due refresh is issued before any further ACTIVE, so consecutive AUTO-REFRESH commands stay within REFI_CYC plus or minus one access length (T_RCD+CAS_LAT+T_WR+T_RP+T_RFC+4 cycles).
- R12: Masked bytes keep their old content. A later read returns the new data in the unmasked bytes and the previous data in the masked bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Flat word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Write byte mask, 1 = keep old byte |
| req_ready | output | 1 | Controller idle and no refresh due |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 16 | Returned read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed row / column address |
| sd_dqm | output | 2 | Byte mask to the memory |
| sd_dq_out | output | 16 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for the DQ buffer |
| sd_dq_in | input | 16 | Data returned from the memory |

## Verification
A bad wait counter shows up at the command pins within the same access. The READ or WRITE lands off the T_RCD slot, or the next ACTIVE breaks the recovery gap, and the protocol monitor catches it on that very command. A bad read-capture pipe moves or drops `rd_valid` relative to READ, so the next returned word fails its latency or data check. A stuck or mis-cleared refresh flag either starves refresh, which breaks the interval bound one period later, or keeps `req_ready` low forever, which the watchdog ends. A mis-sliced address or mask only shows on a read-back, so every write in the sweeps is followed by a read of the same word.

// File: rtl/sdram_word_pkg.sv
`timescale 1ns/1ps
package sdram_word_pkg;
   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP  = 4'b0111,
      CMD_ACT  = 4'b0011,
      CMD_RD   = 4'b0101,
      CMD_WR   = 4'b0100,
      CMD_REF  = 4'b0001
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROWWAIT,
      ST_RDREC,
      ST_WRREC,
      ST_REFWAIT
   } seq_st_e;
endpackage

// File: rtl/sdram_addr_split.sv
`timescale 1ns/1ps
module sdram_addr_split #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 12,
   parameter int COL_W  = 8,
   localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
   input  logic [ADDR_W-1:0] flat,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   localparam int ROW_LO  = COL_W;
   localparam int BANK_LO = COL_W + ROW_W;

   assign col  = flat[COL_W-1:0];
   assign row  = flat[ROW_LO +: ROW_W];
   assign bank = flat[BANK_LO +: BANK_W];
endmodule

// File: rtl/sdram_refresh_tick.sv
`timescale 1ns/1ps
module sdram_refresh_tick #(
   parameter int REFI_CYC = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic due
);
   localparam int TW = $clog2(REFI_CYC + 1);
   localparam logic [TW-1:0] RELOAD = TW'(REFI_CYC - 1);

   logic [TW-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr <= RELOAD;
         due <= 1'b0;
      end else begin
         if (tmr == '0) begin
            tmr <= RELOAD;
            due <= 1'b1;
         end else begin
            tmr <= tmr - 1'b1;
            if (ack) due <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdram_read_capture.sv
`timescale 1ns/1ps
module sdram_read_capture #(
   parameter int DATA_W  = 16,
   parameter int CAS_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [DATA_W-1:0] dq_in,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   logic [CAS_LAT:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe  <= '0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         pipe  <= {pipe[CAS_LAT-1:0], issue};
         valid <= pipe[CAS_LAT];
         if (pipe[CAS_LAT]) data <= dq_in;
      end
   end
endmodule

// File: rtl/sdram_word_ctrl.sv
`timescale 1ns/1ps
module sdram_word_ctrl
   import sdram_word_pkg::*;
#(
   parameter int BANK_W   = 2,
   parameter int ROW_W    = 12,
   parameter int COL_W    = 8,
   parameter int DATA_W   = 16,
   parameter int CAS_LAT  = 2,
   parameter int T_RCD    = 2,
   parameter int T_WR     = 2,
   parameter int T_RP     = 2,
   parameter int T_RFC    = 7,
   parameter int REFI_CYC = 1950
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   input  logic                            req_write,
   input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]               req_wdata,
   input  logic [DATA_W/8-1:0]             req_mask,
   output logic                            req_ready,
   output logic                            rd_valid,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            sd_cs_n,
   output logic                            sd_ras_n,
   output logic                            sd_cas_n,
   output logic                            sd_we_n,
   output logic [BANK_W-1:0]               sd_ba,
   output logic [ROW_W-1:0]                sd_a,
   output logic [DATA_W/8-1:0]             sd_dqm,
   output logic [DATA_W-1:0]               sd_dq_out,
   output logic                            sd_dq_oe,
   input  logic [DATA_W-1:0]               sd_dq_in
);
   localparam int MASK_W   = DATA_W / 8;
   localparam int AP_BIT   = 10;
   localparam int RD_HOLD  = CAS_LAT + T_RP;
   localparam int WR_HOLD  = T_WR + T_RP;
   localparam int M1       = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
   localparam int M2       = (M1 > T_RFC) ? M1 : T_RFC;
   localparam int WAIT_MAX = (M2 > T_RCD) ? M2 : T_RCD;
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);

   // elaboration-time parameter checks
   if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_cl
      $error("CAS_LAT must be 2 or 3");
   end
   if (ROW_W <= AP_BIT || COL_W >= AP_BIT) begin : g_bad_geom
      $error("row must cover the precharge bit and column must stay below it");
   end
   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("DATA_W must be whole bytes");
   end
   if (T_RCD < 1 || T_WR < 1 || T_RP < 1 || T_RFC < 1) begin : g_bad_t
      $error("timing counts must be at least 1");
   end
   if (REFI_CYC <= 2 * (T_RCD + WAIT_MAX + T_RFC)) begin : g_bad_refi
      $error("refresh interval too short for one access plus refresh");
   end

   // address slicing
   logic [BANK_W-1:0] in_bank;
   logic [ROW_W-1:0]  in_row;
   logic [COL_W-1:0]  in_col;

   sdram_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
      .flat (req_addr),
      .bank (in_bank),
      .row  (in_row),
      .col  (in_col)
   );

   // refresh schedule
   logic ref_due;
   logic ref_issue;

   sdram_refresh_tick #(.REFI_CYC(REFI_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .ack   (ref_issue),
      .due   (ref_due)
   );

   // sequencer state
   seq_st_e            st;
   logic [CNT_W-1:0]   cnt;
   sd_cmd_e            cmd_q;
   logic [BANK_W-1:0]  ba_q;
   logic [ROW_W-1:0]   a_q;
   logic [MASK_W-1:0]  dqm_q;
   logic [DATA_W-1:0]  dout_q;
   logic               oe_q;
   logic               lat_wr;
   logic [BANK_W-1:0]  lat_bank;
   logic [COL_W-1:0]   lat_col;
   logic [DATA_W-1:0]  lat_wdata;
   logic [MASK_W-1:0]  lat_mask;
   logic [ROW_W-1:0]   col_word;
   logic               rd_issue;

   assign req_ready = (st == ST_IDLE) && !ref_due;
   assign ref_issue = (st == ST_IDLE) && ref_due;
   assign rd_issue  = (st == ST_ROWWAIT) && (cnt == '0) && !lat_wr;

   always_comb begin
      col_word              = '0;
      col_word[COL_W-1:0]   = lat_col;
      col_word[AP_BIT]      = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         cmd_q     <= CMD_NOP;
         ba_q      <= '0;
         a_q       <= '0;
         dqm_q     <= '0;
         dout_q    <= '0;
         oe_q      <= 1'b0;
         lat_wr    <= 1'b0;
         lat_bank  <= '0;
         lat_col   <= '0;
         lat_wdata <= '0;
         lat_mask  <= '0;
      end else begin
         cmd_q <= CMD_NOP;
         oe_q  <= 1'b0;
         dqm_q <= '0;
         unique case (st)
            ST_IDLE: begin
               if (ref_due) begin
                  cmd_q <= CMD_REF;
                  ba_q  <= '0;
                  a_q   <= '0;
                  cnt   <= CNT_W'(T_RFC - 1);
                  st    <= ST_REFWAIT;
               end else if (req_valid) begin
                  cmd_q     <= CMD_ACT;
                  ba_q      <= in_bank;
                  a_q       <= in_row;
                  lat_wr    <= req_write;
                  lat_bank  <= in_bank;
                  lat_col   <= in_col;
                  lat_wdata <= req_wdata;
                  lat_mask  <= req_mask;
                  cnt       <= CNT_W'(T_RCD - 1);
                  st        <= ST_ROWWAIT;
               end
            end
            ST_ROWWAIT: begin
               if (cnt == '0) begin
                  ba_q <= lat_bank;
                  a_q  <= col_word;
                  if (lat_wr) begin
                     cmd_q  <= CMD_WR;
                     oe_q   <= 1'b1;
                     dqm_q  <= lat_mask;
                     dout_q <= lat_wdata;
                     cnt    <= CNT_W'(WR_HOLD - 1);
                     st     <= ST_WRREC;
                  end else begin
                     cmd_q  <= CMD_RD;
                     cnt    <= CNT_W'(RD_HOLD - 1);
                     st     <= ST_RDREC;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_RDREC, ST_WRREC, ST_REFWAIT: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // read return path
   sdram_read_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (rd_issue),
      .dq_in (sd_dq_in),
      .valid (rd_valid),
      .data  (rd_data)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba     = ba_q;
   assign sd_a      = a_q;
   assign sd_dqm    = dqm_q;
   assign sd_dq_out = dout_q;
   assign sd_dq_oe  = oe_q;
endmodule

// File: rtl/sdram_word_ctrl_chk.sv
`timescale 1ns/1ps
module sdram_word_ctrl_chk #(
   parameter int CAS_LAT  = 2,
   parameter int T_RCD    = 2,
   parameter int T_WR     = 2,
   parameter int T_RP     = 2,
   parameter int T_RFC    = 7,
   parameter int REFI_CYC = 1950
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic ap_bit,
   input logic dq_oe,
   input logic rd_valid,
   input logic req_ready
);
   localparam int SLACK = T_RCD + CAS_LAT + T_WR + T_RP + T_RFC + 4;
   localparam logic [15:0] SAT = 16'hFFFF;

   logic [3:0] cmd;
   assign cmd = {cs_n, ras_n, cas_n, we_n};

   logic is_act, is_rd, is_wr, is_ref, is_nop;
   assign is_nop = (cmd == 4'b0111);
   assign is_act = (cmd == 4'b0011);
   assign is_rd  = (cmd == 4'b0101);
   assign is_wr  = (cmd == 4'b0100);
   assign is_ref = (cmd == 4'b0001);

   logic [15:0] since_act, since_rd, since_last, since_ref, need;
   logic [1:0]  last_kind;   // 0 none, 1 read, 2 write, 3 refresh

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act  <= SAT;
         since_rd   <= SAT;
         since_last <= SAT;
         since_ref  <= '0;
         last_kind  <= 2'd0;
      end else begin
         since_act  <= is_act ? 16'd1 : ((since_act == SAT) ? SAT : since_act + 1'b1);
         since_rd   <= is_rd  ? 16'd1 : ((since_rd  == SAT) ? SAT : since_rd  + 1'b1);
         since_ref  <= is_ref ? 16'd1 : ((since_ref == SAT) ? SAT : since_ref + 1'b1);
         if (is_rd || is_wr || is_ref) begin
            since_last <= 16'd1;
            last_kind  <= is_rd ? 2'd1 : (is_wr ? 2'd2 : 2'd3);
         end else begin
            since_last <= (since_last == SAT) ? SAT : since_last + 1'b1;
         end
      end
   end

   always_comb begin
      unique case (last_kind)
         2'd1:    need = 16'(CAS_LAT + T_RP);
         2'd2:    need = 16'(T_WR + T_RP);
         2'd3:    need = 16'(T_RFC);
         default: need = 16'd0;
      endcase
   end

   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      is_nop || is_act || is_rd || is_wr || is_ref);                          // R2
   AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd || is_wr) |-> ap_bit);                                           // R4
   AST_ROW_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd || is_wr) |-> (since_act == 16'(T_RCD)));                        // R5
   AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> is_wr);                                                       // R6
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> dq_oe);                                                       // R6
   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (since_rd == 16'(CAS_LAT + 1)));                           // R7
   AST_RD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rd == 16'(CAS_LAT + 1)) |-> rd_valid);                           // R7
   AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act || is_ref) |-> (since_last > need));                            // R8
   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> is_nop);                                                  // R9
   AST_REFRESH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      since_ref <= 16'(REFI_CYC + SLACK));                                    // R11
endmodule

bind sdram_word_ctrl sdram_word_ctrl_chk #(
   .CAS_LAT  (CAS_LAT),
   .T_RCD    (T_RCD),
   .T_WR     (T_WR),
   .T_RP     (T_RP),
   .T_RFC    (T_RFC),
   .REFI_CYC (REFI_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (sd_cs_n),
   .ras_n     (sd_ras_n),
   .cas_n     (sd_cas_n),
   .we_n      (sd_we_n),
   .ap_bit    (sd_a[AP_BIT]),
   .dq_oe     (sd_dq_oe),
   .rd_valid  (rd_valid),
   .req_ready (req_ready)
);

// File: tb/sdram_word_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_word_ctrl_tb;
   localparam int REFI  = 64;
   localparam int TRCD  = 2;
   localparam int CL    = 2;
   localparam int TWR   = 2;
   localparam int TRP   = 2;
   localparam int TRFC  = 7;
   localparam int SLACK = TRCD + CL + TWR + TRP + TRFC + 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [21:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rd_valid;
   logic [15:0] rd_data;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [11:0] sd_a;
   logic [1:0]  sd_dqm;
   logic [15:0] sd_dq_out;
   logic        sd_dq_oe;
   logic [15:0] sd_dq_in = '0;

   sdram_word_ctrl #(.CAS_LAT(CL), .T_RCD(TRCD), .T_WR(TWR), .T_RP(TRP),
                     .T_RFC(TRFC), .REFI_CYC(REFI)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [15:0] seed(input logic [21:0] a);
      return a[15:0] ^ {a[21:16], a[21:16], 4'h9} ^ 16'h5A3C;
   endfunction

   // memory model and expectation store (kept apart)
   logic [15:0] mdl_mem [int];
   logic [15:0] exp_mem [int];
   logic [15:0] exp_q [$];

   function automatic logic [15:0] mdl_get(input logic [21:0] a);
      return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : seed(a);
   endfunction
   function automatic logic [15:0] exp_get(input logic [21:0] a);
      return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : seed(a);
   endfunction
   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
      return {m[1] ? old[15:8] : nw[15:8], m[0] ? old[7:0] : nw[7:0]};
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // monitor state
   logic [3:0]  cmd;
   bit          open_b [4];
   logic [11:0] open_row [4];
   int          act_idx = 0, rd_idx = -1000, last_kind = 0, last_idx = -1000;
   int          last_ref = -1;
   bit          gap_clean = 1'b0, prev_clean = 1'b0;
   logic [15:0] rq [0:CL];
   logic [21:0] acc_addr;
   logic [15:0] acc_wdata;
   logic [1:0]  acc_mask;
   logic [21:0] full;
   int          need;

   initial for (int i = 0; i <= CL; i++) rq[i] = '0;

   always @(negedge clk) if (rst_n) begin
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      for (int i = 0; i < CL; i++) rq[i] = rq[i+1];
      rq[CL] = '0;
      chk(sd_dq_oe == (cmd == 4'b0100), "R6 dq drive only in write cycle", sd_dq_oe, cmd == 4'b0100);
      if (cmd != 4'b0111) chk(!req_ready, "R9 ready low while commanding", req_ready, 0);
      case (last_kind)
         1: need = CL + TRP;
         2: need = TWR + TRP;
         3: need = TRFC;
         default: need = 0;
      endcase
      case (cmd)
         4'b0111: ;
         4'b0011: begin
            chk(cyc - last_idx > need, "R8 gap before ACTIVE", cyc - last_idx, need + 1);
            chk(!open_b[sd_ba], "R3 active to open bank", open_b[sd_ba], 0);
            chk({sd_ba, sd_a} == acc_addr[21:8], "R3 bank/row", {sd_ba, sd_a}, acc_addr[21:8]);
            open_b[sd_ba] = 1'b1; open_row[sd_ba] = sd_a; act_idx = cyc; gap_clean = 1'b0;
         end
         4'b0101, 4'b0100: begin
            chk(open_b[sd_ba], "R3 column command to open bank", open_b[sd_ba], 1);
            chk({sd_a[11], sd_a[10], sd_a[9:8]} == 4'b0100, "R4 precharge bit / spare bits",
                {sd_a[11], sd_a[10], sd_a[9:8]}, 4'b0100);
            chk(cyc - act_idx == TRCD, "R5 active to column", cyc - act_idx, TRCD);
            full = {sd_ba, open_row[sd_ba], sd_a[7:0]};
            chk(full == acc_addr, "R3 column address", full, acc_addr);
            open_b[sd_ba] = 1'b0;
            last_idx = cyc;
            if (cmd == 4'b0100) begin
               last_kind = 2;
               chk(sd_dqm == acc_mask, "R6 write mask", sd_dqm, acc_mask);
               chk(sd_dq_out == acc_wdata, "R6 write data", sd_dq_out, acc_wdata);
               mdl_mem[int'(full)] = merge(mdl_get(full), sd_dq_out, sd_dqm);
            end else begin
               last_kind = 1;
               chk(sd_dqm == 2'b00, "R7 read mask", sd_dqm, 0);
               rq[CL] = mdl_get(full);
               rd_idx = cyc;
            end
         end
         4'b0001: begin
            chk(cyc - last_idx > need, "R8 gap before REFRESH", cyc - last_idx, need + 1);
            chk(!open_b[0] && !open_b[1] && !open_b[2] && !open_b[3], "R8 refresh with open row",
                {open_b[3], open_b[2], open_b[1], open_b[0]}, 0);
            if (last_ref >= 0) begin
               if (gap_clean && prev_clean)
                  chk(cyc - last_ref == REFI, "R10 idle refresh interval", cyc - last_ref, REFI);
               else
                  chk((cyc - last_ref <= REFI + SLACK) && (cyc - last_ref >= REFI - SLACK),
                      "R11 busy refresh interval", cyc - last_ref, REFI);
            end
            prev_clean = gap_clean; gap_clean = 1'b1;
            last_ref = cyc; last_kind = 3; last_idx = cyc;
         end
         default: chk(1'b0, "R2 illegal command", cmd, 4'b0111);
      endcase
      if (rd_valid) begin
         chk(cyc == rd_idx + CL + 1, "R7 read latency", cyc - rd_idx, CL + 1);
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected read data", rd_data, 0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e, "R12 read data", rd_data, e);
         end
      end
      if (req_valid && req_ready) begin
         acc_addr = req_addr; acc_wdata = req_wdata; acc_mask = req_mask;
         if (req_write) exp_mem[int'(req_addr)] = merge(exp_get(req_addr), req_wdata, req_mask);
         else           exp_q.push_back(exp_get(req_addr));
      end
      sd_dq_in = rq[0];
   end

   task automatic access(input bit wr, input logic [21:0] a, input logic [15:0] d, input logic [1:0] m);
      bit ok;
      @(posedge clk); #2;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      forever begin
         ok = req_ready;
         @(posedge clk);
         if (ok) break;
         #2;
      end
      #2 req_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [21:0] a;
      logic [15:0] lf;
      repeat (2) @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 nop in reset",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
      chk(!sd_dq_oe && !rd_valid, "R1 quiet outputs in reset", {sd_dq_oe, rd_valid}, 0);
      @(posedge clk); #2 rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 state after reset",
          {req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b10111);

      // bank x row x mask sweep: masked write then read-back
      for (int b = 0; b < 4; b++)
         for (int r = 0; r < 3; r++)
            for (int m = 0; m < 4; m++) begin
               a = {2'(b), (r == 0) ? 12'h000 : (r == 1) ? 12'hAAA : 12'hFFF, 8'(m * 61 + b)};
               access(1'b1, a, 16'(b * 4099 + r * 331 + m * 17 + 16'h1234), 2'(m));
               access(1'b0, a, 16'h0, 2'b00);
            end

      // full column sweep in one row
      for (int c = 0; c < 256; c++) access(1'b1, {2'd1, 12'h123, 8'(c)}, 16'(c * 257 ^ 16'hC0DE), 2'b00);
      for (int c = 0; c < 256; c++) access(1'b0, {2'd1, 12'h123, 8'(c)}, 16'h0, 2'b00);

      // idle: refresh at exact interval
      repeat (5 * REFI) @(posedge clk);

      // continuous mixed traffic: refresh must still get through
      lf = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         a  = {lf[15:14], 4'(lf[3:0]), 8'h0, lf[11:4]};
         access(lf[0], a, lf ^ 16'h3C3C, lf[6:5]);
      end

      repeat (40) @(posedge clk);
      chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule